// File: doc/BRIEF.md
# SDRAM Self-Refresh Suspend Sequencer

This block sits beside an SDRAM controller and walks the memory into self-refresh when software asks, so that the memory clock can be stopped and the SDRAM pins frozen before the system powers down. Software controls it through a single-cycle register bus with three registers: a control/status register, a refresh-spacing register and a configuration register. In normal operation the block issues periodic AUTO REFRESH commands. A burst mode issues refreshes at a short fixed spacing for a bounded time. Software must leave burst mode before it requests suspend.

The suspend handshake runs in order. Software sets the request bit and polls the ready bit. It then halts the memory clock, freezes the pins, and finally clears the request bit. A wake input undoes the halt and the freeze, raises CKE, waits out the exit time and returns the block to normal refresh.

Register map (addresses 0 to 2, other addresses read 0):
- Address 0, control/status: bit0 request, bit1 clock halt, bit2 pin hold, bit3 ready (read only).
- Address 1: refresh spacing, REFI_W bits, reset value all ones.
- Address 2: configuration, bit0 burst enable.

Command pins {cs_n, ras_n, cas_n, we_n} are encoded as follows: NOP 0111, PRECHARGE ALL 0010, refresh 0001. Refresh with CKE high is AUTO REFRESH. Refresh issued in the cycle CKE goes low is self-refresh entry.

Top module: `memsleep_ctrl`

## Requirements
- R1: After reset, CKE is 1, the command is NOP (0111) and mclk_en is 1. The control register reads 0, the spacing register reads all ones and the configuration register reads 0.
- R2: While idle with burst disabled, an AUTO REFRESH (0001, CKE 1) appears every spacing+1 cycles. Writing the spacing or configuration register restarts the count, so the first refresh appears in the cycle that lies spacing cycles after the write edge.
- R3: With burst enabled (configuration bit0 = 1), idle refreshes are spaced BURST_GAP cycles. They occur only during the first BURST_LEN cycles after the configuration write and stop after that.
- R4: A request (control bit0 = 1) written while burst is enabled, or while the sequencer is not idle, is rejected. Bit0 stays 0 and no PRECHARGE ALL is issued.
- R5: An accepted request issues PRECHARGE ALL (0010) in the next cycle. Self-refresh entry (0001 with CKE falling to 0) follows TRP cycles after the PRECHARGE ALL.
- R6: Ready (bit3) reads 1 from the cycle after self-refresh entry until wake, and CKE stays 0 throughout that period.
- R7: A clock-halt write (bit1) is accepted only while ready. It drives mclk_en to 0. At any other time it is ignored and bit1 reads 0.
- R8: A pin-hold write (bit2) is accepted only while the clock is halted. While the hold is active, the command pins and CKE keep their levels.
- R9: Clearing the request bit once the pins are held changes none of CKE, the command, mclk_en, ready or the hold.
- R10: Wake while the clock is halted or the pins are held makes CKE and mclk_en 1 and makes hold and ready 0 in the next cycle. Wake in any other state is ignored.
- R11: The exit phase lasts TXSR cycles, during which requests are rejected. After it, the control register reads 0, a new request is accepted and periodic refresh resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| wake | input | 1 | Wake event |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_cke | output | 1 | SDRAM clock enable |
| mclk_en | output | 1 | Memory clock enable to the controller core |

## Verification
Four spacing values (0, 2, 5, 9) are each counted over a fixed window. Wrong-by-one spacing and a missed restart give distinct refresh counts. A burst window longer than BURST_LEN separates burst spacing from the burst cut-off, and a suspend request made then confirms the rejection. The suspend handshake is driven in order and also out of order: halt before ready, wake while only ready, and a request on the last exit cycle against one on the first idle cycle. This pins the TRP and TXSR cycle counts exactly. A second pass wakes from the halted-but-unheld state and then confirms that refresh resumes.

// File: rtl/memsleep_pkg.sv
package memsleep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHG,
        ST_SR_ENTER,
        ST_SR_ACTIVE,
        ST_CLK_OFF,
        ST_PADS_HELD,
        ST_EXIT
    } sleep_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    typedef struct packed {
        sd_cmd_t cmd;
        logic    cke;
    } pad_t;

    localparam sd_cmd_t CMD_NOP  = sd_cmd_t'(4'b0111);
    localparam sd_cmd_t CMD_PALL = sd_cmd_t'(4'b0010);
    localparam sd_cmd_t CMD_REF  = sd_cmd_t'(4'b0001);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_REFI = 2'd1;
    localparam logic [1:0] ADDR_CFG  = 2'd2;

    localparam int BIT_REQ   = 0;
    localparam int BIT_HALT  = 1;
    localparam int BIT_HOLD  = 2;
    localparam int BIT_READY = 3;

    function automatic logic in_self_refresh(sleep_state_e s);
        return (s == ST_SR_ACTIVE) || (s == ST_CLK_OFF) || (s == ST_PADS_HELD);
    endfunction

    function automatic logic clock_halted(sleep_state_e s);
        return (s == ST_CLK_OFF) || (s == ST_PADS_HELD);
    endfunction

endpackage

// File: rtl/memsleep_regs.sv
module memsleep_regs
    import memsleep_pkg::*;
#(
    parameter int REFI_W = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              in_idle,
    input  logic              in_exit,
    input  logic              ready,
    input  logic              halt_on,
    input  logic              hold_on,
    output logic [DATA_W-1:0] rdata,
    output logic [REFI_W-1:0] refi,
    output logic              burst_on,
    output logic              start,
    output logic              halt_req,
    output logic              hold_req,
    output logic              timer_restart
);

    logic ctrl_we;
    logic sr_req;
    logic unused_hi_bits;

    assign ctrl_we        = we && (addr == ADDR_CTRL);
    assign start          = ctrl_we && wdata[BIT_REQ] && in_idle && !burst_on;
    assign halt_req       = ctrl_we && wdata[BIT_HALT];
    assign hold_req       = ctrl_we && wdata[BIT_HOLD];
    assign timer_restart  = we && ((addr == ADDR_REFI) || (addr == ADDR_CFG));
    assign unused_hi_bits = ^wdata[DATA_W-1:REFI_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            refi     <= '1;
            burst_on <= 1'b0;
            sr_req   <= 1'b0;
        end else begin
            if (we && addr == ADDR_REFI) refi <= wdata[REFI_W-1:0];
            if (we && addr == ADDR_CFG)  burst_on <= wdata[0];
            if (in_exit)                 sr_req <= 1'b0;
            else if (start)              sr_req <= 1'b1;
            else if (ctrl_we && !wdata[BIT_REQ]) sr_req <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[BIT_REQ]   = sr_req;
                rdata[BIT_HALT]  = halt_on;
                rdata[BIT_HOLD]  = hold_on;
                rdata[BIT_READY] = ready;
            end
            ADDR_REFI: rdata[REFI_W-1:0] = refi;
            ADDR_CFG:  rdata[0] = burst_on;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/memsleep_refresh.sv
module memsleep_refresh
    import memsleep_pkg::*;
#(
    parameter int REFI_W    = 14,
    parameter int BURST_GAP = 13,
    parameter int BURST_LEN = 16383
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              restart,
    input  logic              burst_on,
    input  logic [REFI_W-1:0] refi,
    output logic              tick
);

    localparam int BCNT_W = $clog2(BURST_LEN + 1);
    localparam logic [REFI_W-1:0] GAP_LIM  = REFI_W'(BURST_GAP - 1);
    localparam logic [BCNT_W-1:0] BURST_END = BCNT_W'(BURST_LEN);

    logic [REFI_W-1:0] cnt;
    logic [BCNT_W-1:0] bcnt;
    logic [REFI_W-1:0] limit;
    logic              hit;
    logic              burst_live;

    assign limit      = burst_on ? GAP_LIM : refi;
    assign hit        = (cnt == limit);
    assign burst_live = (bcnt < BURST_END);
    assign tick       = en && hit && (!burst_on || burst_live);

    always_ff @(posedge clk) begin
        if (rst || restart || !en) cnt <= '0;
        else if (hit)              cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || restart)            bcnt <= '0;
        else if (burst_on && burst_live) bcnt <= bcnt + 1'b1;
    end

endmodule

// File: rtl/memsleep_fsm.sv
module memsleep_fsm
    import memsleep_pkg::*;
#(
    parameter int TRP  = 3,
    parameter int TXSR = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    halt_req,
    input  logic    hold_req,
    input  logic    wake,
    input  logic    refresh_tick,
    output sd_cmd_t cmd,
    output logic    cke,
    output logic    mclk_en,
    output logic    ready,
    output logic    hold,
    output logic    in_idle,
    output logic    in_exit
);

    localparam int WAIT_MAX = (TRP > TXSR) ? TRP : TXSR;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [CNT_W-1:0] TRP_LAST  = CNT_W'(TRP - 1);
    localparam logic [CNT_W-1:0] TXSR_LAST = CNT_W'(TXSR - 1);

    sleep_state_e     state_q, state_d;
    logic [CNT_W-1:0] wait_cnt;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_PRECHG;
            ST_PRECHG:    if (wait_cnt == TRP_LAST) state_d = ST_SR_ENTER;
            ST_SR_ENTER:  state_d = ST_SR_ACTIVE;
            ST_SR_ACTIVE: if (halt_req) state_d = ST_CLK_OFF;
            ST_CLK_OFF:   if (wake) state_d = ST_EXIT;
                          else if (hold_req) state_d = ST_PADS_HELD;
            ST_PADS_HELD: if (wake) state_d = ST_EXIT;
            ST_EXIT:      if (wait_cnt == TXSR_LAST) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            wait_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) wait_cnt <= '0;
            else if (state_q == ST_PRECHG || state_q == ST_EXIT) wait_cnt <= wait_cnt + 1'b1;
            else wait_cnt <= '0;
        end
    end

    always_comb begin
        cmd = CMD_NOP;
        unique case (state_q)
            ST_IDLE:     if (refresh_tick) cmd = CMD_REF;
            ST_PRECHG:   if (wait_cnt == '0) cmd = CMD_PALL;
            ST_SR_ENTER: cmd = CMD_REF;
            default:     cmd = CMD_NOP;
        endcase
    end

    assign cke     = !(in_self_refresh(state_q) || state_q == ST_SR_ENTER);
    assign mclk_en = !clock_halted(state_q);
    assign ready   = in_self_refresh(state_q);
    assign hold    = (state_q == ST_PADS_HELD);
    assign in_idle = (state_q == ST_IDLE);
    assign in_exit = (state_q == ST_EXIT);

endmodule

// File: rtl/memsleep_ctrl.sv
module memsleep_ctrl
    import memsleep_pkg::*;
#(
    parameter int REFI_W    = 14,
    parameter int DATA_W    = 16,
    parameter int TRP       = 3,
    parameter int TXSR      = 8,
    parameter int BURST_GAP = 13,
    parameter int BURST_LEN = 16383
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_cke,
    output logic              mclk_en
);

    logic [REFI_W-1:0] refi;
    logic burst_on, start, halt_req, hold_req, timer_restart;
    logic in_idle, in_exit, sr_ready, hold_on, refresh_tick, live_cke;
    sd_cmd_t live_cmd;
    pad_t    live_pad, held_pad, drive_pad;

    memsleep_regs #(.REFI_W(REFI_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
        .in_idle(in_idle), .in_exit(in_exit), .ready(sr_ready),
        .halt_on(!mclk_en), .hold_on(hold_on), .rdata(bus_rdata),
        .refi(refi), .burst_on(burst_on), .start(start),
        .halt_req(halt_req), .hold_req(hold_req), .timer_restart(timer_restart)
    );

    memsleep_refresh #(.REFI_W(REFI_W), .BURST_GAP(BURST_GAP), .BURST_LEN(BURST_LEN)) u_refresh (
        .clk(clk), .rst(rst), .en(in_idle), .restart(timer_restart),
        .burst_on(burst_on), .refi(refi), .tick(refresh_tick)
    );

    memsleep_fsm #(.TRP(TRP), .TXSR(TXSR)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .halt_req(halt_req),
        .hold_req(hold_req), .wake(wake), .refresh_tick(refresh_tick),
        .cmd(live_cmd), .cke(live_cke), .mclk_en(mclk_en), .ready(sr_ready),
        .hold(hold_on), .in_idle(in_idle), .in_exit(in_exit)
    );

    assign live_pad.cmd = live_cmd;
    assign live_pad.cke = live_cke;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_pad.cmd <= CMD_NOP;
            held_pad.cke <= 1'b1;
        end else if (!hold_on) begin
            held_pad <= live_pad;
        end
    end

    assign drive_pad = hold_on ? held_pad : live_pad;
    assign sd_cs_n   = drive_pad.cmd.cs_n;
    assign sd_ras_n  = drive_pad.cmd.ras_n;
    assign sd_cas_n  = drive_pad.cmd.cas_n;
    assign sd_we_n   = drive_pad.cmd.we_n;
    assign sd_cke    = drive_pad.cke;

endmodule

// File: rtl/memsleep_chk.sv
module memsleep_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cmd_bits,
    input logic       cke,
    input logic       mclk_en,
    input logic       ready,
    input logic       hold,
    input logic       burst_on
);

    // R5: self-refresh entry coincides with CKE falling
    a_r5_entry_on_cke_fall: assert property (@(posedge clk) disable iff (rst)
        (cmd_bits == 4'b0001 && !cke) |-> $past(cke));

    // R4: precharge-all only follows a cycle with burst disabled
    a_r4_pall_needs_no_burst: assert property (@(posedge clk) disable iff (rst)
        (cmd_bits == 4'b0010) |-> $past(!burst_on));

    // R7: memory clock halted only while in self-refresh
    a_r7_halt_only_when_ready: assert property (@(posedge clk) disable iff (rst)
        !mclk_en |-> ready);

    // R8: held pins do not move
    a_r8_pins_frozen: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold)) |-> ($stable(cmd_bits) && $stable(cke)));

    // R10: clock restart releases hold and raises CKE
    a_r10_wake_release: assert property (@(posedge clk) disable iff (rst)
        $rose(mclk_en) |-> (cke && !hold && !ready));

    // R6: ready drops only with clock running and CKE high
    a_r6_ready_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> (mclk_en && cke));

endmodule

bind memsleep_ctrl memsleep_chk i_memsleep_chk (
    .clk(clk), .rst(rst),
    .cmd_bits({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .cke(sd_cke), .mclk_en(mclk_en), .ready(sr_ready),
    .hold(hold_on), .burst_on(burst_on)
);

// File: tb/test_memsleep_ctrl.sv
module test_memsleep_ctrl;

    localparam int TRP = 3;
    localparam int TXSR = 8;
    localparam int GAP = 4;
    localparam int BLEN = 64;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_REFI = 2'd1;
    localparam logic [1:0] A_CFG  = 2'd2;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PALL = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;

    localparam int NVEC = 4;
    localparam int V_REFI [NVEC] = '{5, 0, 9, 2};
    localparam int V_WIN  [NVEC] = '{60, 20, 50, 30};
    localparam int V_EXP  [NVEC] = '{10, 20, 5, 10};

    logic clk = 1'b0;
    logic rst, we, wake;
    logic [1:0] addr;
    logic [15:0] wdata, rdata;
    logic cs_n, ras_n, cas_n, we_n, cke, mclk_en;
    logic [3:0] cmd;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    memsleep_ctrl #(.TRP(TRP), .TXSR(TXSR), .BURST_GAP(GAP), .BURST_LEN(BLEN)) i_memsleep_ctrl (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
        .bus_rdata(rdata), .wake(wake), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
        .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_cke(cke), .mclk_en(mclk_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic count_refs(input int win, output int c);
        c = 0;
        for (int i = 0; i < win; i++) begin
            if (i > 0) @(negedge clk);
            if (cmd == REF && cke) c++;
        end
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int c;
        bit bad;
        rst = 1'b1; we = 1'b0; wake = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(cke == 1'b1, "R1 cke", cke, 1);
        chk(cmd == NOP, "R1 cmd", cmd, NOP);
        chk(mclk_en == 1'b1, "R1 mclk_en", mclk_en, 1);
        rd(A_CTRL, v); chk(v == 16'h0, "R1 ctrl", v, 0);
        rd(A_REFI, v); chk(v == 16'h3FFF, "R1 refi", v, 16'h3FFF);
        rd(A_CFG, v);  chk(v == 16'h0, "R1 cfg", v, 0);

        // R2 refresh spacing table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_REFI, 16'(V_REFI[i]));
            count_refs(V_WIN[i], c);
            chk(c == V_EXP[i], "R2 refresh count", c, V_EXP[i]);
            rd(A_REFI, v);
            chk(v == 16'(V_REFI[i]), "R2 refi readback", v, V_REFI[i]);
        end

        // R7 halt before ready is ignored
        wr(A_REFI, 16'h3FFF);
        wr(A_CTRL, 16'h2);
        rd(A_CTRL, v);
        chk(v[1] == 1'b0, "R7 early halt bit", v, 0);
        chk(mclk_en == 1'b1, "R7 early halt mclk_en", mclk_en, 1);

        // R3 burst spacing and cut-off
        wr(A_CFG, 16'h1);
        count_refs(100, c);
        chk(c == BLEN / GAP, "R3 burst refresh count", c, BLEN / GAP);

        // R4 request rejected while burst enabled
        wr(A_CTRL, 16'h1);
        rd(A_CTRL, v);
        chk(v[0] == 1'b0, "R4 request bit", v, 0);
        bad = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (cmd == PALL || !cke) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R4 no precharge", bad, 0);
        wr(A_CFG, 16'h0);

        // R5 accepted request: precharge then entry after TRP
        wr(A_CTRL, 16'h1);
        chk(cmd == PALL, "R5 precharge", cmd, PALL);
        repeat (TRP - 1) begin
            @(negedge clk);
            chk(cmd == NOP && cke, "R5 trp wait", cmd, NOP);
        end
        @(negedge clk);
        chk(cmd == REF && !cke, "R5 self-refresh entry", {cmd, cke}, {REF, 1'b0});
        @(negedge clk);
        rd(A_CTRL, v);
        chk(v == 16'h9, "R6 ready", v, 16'h9);

        // R10 wake while only ready is ignored
        pulse_wake();
        rd(A_CTRL, v);
        chk(v == 16'h9 && !cke, "R10 wake ignored", v, 16'h9);

        // R7 halt accepted
        wr(A_CTRL, 16'h3);
        chk(mclk_en == 1'b0, "R7 mclk_en", mclk_en, 0);
        rd(A_CTRL, v);
        chk(v == 16'hB, "R7 ctrl", v, 16'hB);

        // R8 pin hold
        wr(A_CTRL, 16'h7);
        rd(A_CTRL, v);
        chk(v == 16'hF, "R8 ctrl", v, 16'hF);
        chk(cmd == NOP && !cke, "R8 pins", {cmd, cke}, {NOP, 1'b0});

        // R9 clearing the request disturbs nothing
        wr(A_CTRL, 16'h6);
        rd(A_CTRL, v);
        chk(v == 16'hE, "R9 ctrl", v, 16'hE);
        repeat (5) @(negedge clk);
        chk(cmd == NOP && !cke && !mclk_en, "R9 pins", {cmd, cke, mclk_en}, {NOP, 2'b00});

        // R10 wake from held pins
        pulse_wake();
        chk(cke && mclk_en, "R10 cke/mclk", {cke, mclk_en}, 2'b11);
        rd(A_CTRL, v);
        chk(v == 16'h0, "R10 ctrl", v, 0);

        // R11 exit length: last exit cycle rejects, first idle cycle accepts
        repeat (TXSR - 1) @(negedge clk);
        wr(A_CTRL, 16'h1);
        rd(A_CTRL, v);
        chk(cmd != PALL && v[0] == 1'b0, "R11 reject in exit", v, 0);
        wr(A_CTRL, 16'h1);
        chk(cmd == PALL, "R11 accept after exit", cmd, PALL);

        // second pass: wake straight from halted clock
        repeat (TRP + 1) @(negedge clk);
        rd(A_CTRL, v);
        chk(v == 16'h9, "R6 ready second pass", v, 16'h9);
        wr(A_CTRL, 16'h3);
        chk(mclk_en == 1'b0, "R7 second halt", mclk_en, 0);
        pulse_wake();
        chk(cke && mclk_en, "R10 wake from halt", {cke, mclk_en}, 2'b11);
        repeat (TXSR) @(negedge clk);
        wr(A_REFI, 16'd3);
        count_refs(40, c);
        chk(c == 10, "R11 refresh resumed", c, 10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule